// File: doc/BRIEF.md
# Index Register Stack Push/Pull Sequencer

This block runs the data cycles of the four single-byte stack instructions that save or restore an index register: push X, push Y, pull X and pull Y. Fetch and decode stay outside. When the decoder has fetched one of these opcodes, it raises `start` for one cycle with the operation code. That cycle counts as cycle 1 of the instruction. The sequencer then drives the remaining bus cycles on a byte-wide memory port. A push takes three cycles in total and a pull takes four.

The block owns the 8-bit stack pointer. Every stack reference goes to page 1 of the 64 KB space, at address 0x0100 plus the pointer. A push stores the chosen register at the current slot and then moves the pointer down. A pull first moves the pointer up and reads that slot in a later cycle. It then hands the byte back to the register file with a write strobe, together with fresh negative and zero flags and a flag strobe. A push never strobes the flags.

The pointer wraps modulo 256 in both directions. Between instructions, a load port lets the surrounding core set the pointer to any value.

Top module: `stk_sequencer`

## Requirements
- R1: After reset the stack pointer is 0xFF, `busy` is low, and `mem_we`, `mem_re`, `done`, `reg_we` and `flag_we` are all low.
- R2: Every stack access uses address 0x0100 + SP: upper byte 0x01 and lower byte equal to the stack pointer.
- R3: The operation code is 00 for push X, 01 for push Y, 10 for pull X and 11 for pull Y. For a push, the cycle after the `start` cycle is internal, with neither `mem_re` nor `mem_we` asserted. The next cycle writes the selected register value to 0x0100 + SP, with `done` high in that third cycle.
- R4: A push decrements SP by one after its write cycle, and 0x00 wraps to 0xFF.
- R5: For a pull, cycles 2 and 3 are internal cycles with no read and no write. SP shows the incremented value from cycle 3 onward. Cycle 4 reads 0x0100 + SP with `done` high, and SP does not change in that cycle.
- R6: A pull increments SP modulo 256, so a pull at SP 0xFF reads address 0x0100 and leaves SP at 0x00.
- R7: In the read cycle of a pull, `reg_we` is high, `reg_sel` selects the target register (0 for X, 1 for Y), and `reg_wdata` equals `mem_rdata`. `reg_we` is low in every other cycle.
- R8: In the read cycle of a pull, `flag_we` is high, `flag_n` equals bit 7 of the read byte, and `flag_z` is high exactly when the byte is zero. A push never raises `flag_we`.
- R9: While `busy` is high, `start`, `op` and `sp_load` have no effect: the running sequence, the stack pointer and the final SP are unchanged.
- R10: `sp_load` held high for one idle cycle sets SP to `sp_load_val` in the next cycle.
- R11: `done` lasts exactly one cycle, `mem_we` and `mem_re` are never high together, and neither they nor `done` are high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Marks the opcode fetch cycle of a stack instruction |
| op | input | 2 | Operation code: 00 push X, 01 push Y, 10 pull X, 11 pull Y |
| sp_load | input | 1 | Loads the stack pointer while idle |
| sp_load_val | input | 8 | Value for `sp_load` |
| x_val | input | 8 | Current X register value |
| y_val | input | 8 | Current Y register value |
| mem_addr | output | 16 | Memory address, 0x0100 + SP |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| reg_we | output | 1 | Write strobe to the index register file |
| reg_sel | output | 1 | Target register for `reg_we`: 0 = X, 1 = Y |
| reg_wdata | output | 8 | Pulled byte |
| flag_we | output | 1 | Strobe for the N and Z flag outputs |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | High in cycles 2 through the last cycle of an instruction |
| done | output | 1 | High in the last cycle of an instruction |

## Verification
The assertions assume that the memory returns read data in the same cycle as `mem_re`. They also assume that `x_val` and `y_val` hold steady while a push is in progress, as a register file stalled by the core would.

The stimulus holds the index values constant across each operation and models page 1 as a combinational-read array. Each new `start` is raised only in an idle cycle. The only exception is a deliberately noisy run that leaves `start`, a flipped `op` and `sp_load` asserted during a busy window, to show that these inputs are ignored there.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_C2   = 2'd1,
    ST_C3   = 2'd2,
    ST_C4   = 2'd3
  } stk_state_e;

  // bit 1: pull when set, bit 0: Y when set
  typedef enum logic [1:0] {
    OP_PUSH_X = 2'b00,
    OP_PUSH_Y = 2'b01,
    OP_PULL_X = 2'b10,
    OP_PULL_Y = 2'b11
  } stk_op_e;

  function automatic logic op_is_pull(input logic [1:0] o);
    return o[1];
  endfunction

  function automatic logic op_is_y(input logic [1:0] o);
    return o[0];
  endfunction

endpackage

// File: rtl/stk_seq_fsm.sv
`timescale 1ns/1ps
module stk_seq_fsm
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_in,
  output logic [1:0] op_q,
  output logic       busy,
  output logic       sp_inc_evt,
  output logic       sp_dec_evt,
  output logic       wr_cycle,
  output logic       rd_cycle,
  output logic       done
);

  stk_state_e state_q, state_d;
  logic       pull_q;

  assign pull_q = op_is_pull(op_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_C2;
      ST_C2:   state_d = ST_C3;
      ST_C3:   state_d = pull_q ? ST_C4 : ST_IDLE;
      ST_C4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH_X;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) op_q <= op_in;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign sp_inc_evt = (state_q == ST_C2) && pull_q;
  assign wr_cycle   = (state_q == ST_C3) && !pull_q;
  assign sp_dec_evt = wr_cycle;
  assign rd_cycle   = (state_q == ST_C4);
  assign done       = wr_cycle || rd_cycle;

endmodule

// File: rtl/stk_ptr.sv
`timescale 1ns/1ps
module stk_ptr #(
  parameter int unsigned     SP_W     = 8,
  parameter logic [SP_W-1:0] SP_RESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp
);

  // modulo-2^SP_W step, up when up=1
  function automatic logic [SP_W-1:0] sp_step(input logic [SP_W-1:0] v,
                                              input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sp <= SP_RESET;
    else if (load)       sp <= load_val;
    else if (inc || dec) sp <= sp_step(sp, inc);
  end

endmodule

// File: rtl/stk_wb.sv
`timescale 1ns/1ps
module stk_wb
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_cycle,
  input  logic [1:0]        op_q,
  input  logic [DATA_W-1:0] rdata,
  output logic              reg_we,
  output logic              reg_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              flag_we,
  output logic              flag_n,
  output logic              flag_z
);

  function automatic logic neg_of(input logic [DATA_W-1:0] v);
    return v[DATA_W-1];
  endfunction

  function automatic logic zero_of(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  logic pull_rd;
  assign pull_rd   = rd_cycle && op_is_pull(op_q);

  assign reg_we    = pull_rd;
  assign reg_sel   = op_is_y(op_q);
  assign reg_wdata = rdata;
  assign flag_we   = pull_rd;
  assign flag_n    = neg_of(rdata);
  assign flag_z    = zero_of(rdata);

endmodule

// File: rtl/stk_sequencer.sv
`timescale 1ns/1ps
module stk_sequencer
  import stk_pkg::*;
#(
  parameter int unsigned                  DATA_W     = 8,
  parameter int unsigned                  ADDR_W     = 16,
  parameter logic [ADDR_W-DATA_W-1:0]     STACK_PAGE = 1,
  parameter logic [DATA_W-1:0]            SP_RESET   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              sp_load,
  input  logic [DATA_W-1:0] sp_load_val,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              reg_we,
  output logic              reg_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              flag_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              done
);

  logic [1:0] op_q;
  logic       sp_inc_evt, sp_dec_evt, wr_cycle, rd_cycle, sp_load_evt;

  stk_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_in      (op),
    .op_q       (op_q),
    .busy       (busy),
    .sp_inc_evt (sp_inc_evt),
    .sp_dec_evt (sp_dec_evt),
    .wr_cycle   (wr_cycle),
    .rd_cycle   (rd_cycle),
    .done       (done)
  );

  assign sp_load_evt = sp_load && !busy;

  stk_ptr #(.SP_W(DATA_W), .SP_RESET(SP_RESET)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sp_load_evt),
    .load_val (sp_load_val),
    .inc      (sp_inc_evt),
    .dec      (sp_dec_evt),
    .sp       (sp)
  );

  stk_wb #(.DATA_W(DATA_W)) u_wb (
    .rd_cycle  (rd_cycle),
    .op_q      (op_q),
    .rdata     (mem_rdata),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .flag_we   (flag_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
  );

  assign mem_addr  = {STACK_PAGE, sp};
  assign mem_wdata = op_is_y(op_q) ? y_val : x_val;
  assign mem_we    = wr_cycle;
  assign mem_re    = rd_cycle;

endmodule

// File: rtl/stk_sequencer_chk.sv
`timescale 1ns/1ps
module stk_sequencer_chk #(
  parameter int unsigned SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mem_we,
  input logic            mem_re,
  input logic            sp_dec_evt,
  input logic [SP_W-1:0] sp
);

  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R4
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && sp_dec_evt) |=> (sp == $past(sp) - 1'b1));

  // R5
  pull_sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ($past(busy) && (sp == $past(sp))));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind stk_sequencer stk_sequencer_chk #(.SP_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .sp_dec_evt (sp_dec_evt),
  .sp         (sp)
);

// File: tb/stk_sequencer_tb.sv
`timescale 1ns/1ps
module stk_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        sp_load = 1'b0;
  logic [7:0]  sp_load_val = 8'h00;
  logic [7:0]  x_val = 8'h00, y_val = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, reg_wdata, sp;
  logic        mem_we, mem_re, reg_we, reg_sel, flag_we, flag_n, flag_z, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] page [256];
  logic [7:0] shadow [256];
  logic [7:0] m_sp;

  typedef struct packed {
    logic        pl, we, re, dn, rwe, sel, fwe, n, z;
    logic [15:0] addr;
    logic [7:0]  wdata, rdat, spv;
  } item_t;

  item_t exp_q[$];

  stk_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .sp_load(sp_load), .sp_load_val(sp_load_val),
    .x_val(x_val), .y_val(y_val),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z),
    .sp(sp), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  // page-1 memory model, combinational read
  assign mem_rdata = page[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) page[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops one expected item per busy cycle
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "R11", "watchdog expired", 16'(cyc), 16'd0);
      finish_run();
    end
    if (rst_n) begin
      if (busy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "busy with no expected cycle", 16'(busy), 16'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mem_we == it.we && mem_re == it.re && done == it.dn,
              it.pl ? "R5" : "R3", "we/re/done",
              {13'd0, mem_we, mem_re, done}, {13'd0, it.we, it.re, it.dn});
          if (it.we || it.re)
            chk(mem_addr == it.addr, "R2", "address", mem_addr, it.addr);
          if (it.we)
            chk(mem_wdata == it.wdata, "R3", "write data", {8'd0, mem_wdata}, {8'd0, it.wdata});
          chk(sp == it.spv, it.pl ? "R6" : "R4", "stack pointer", {8'd0, sp}, {8'd0, it.spv});
          chk(reg_we == it.rwe, "R7", "reg_we", {15'd0, reg_we}, {15'd0, it.rwe});
          if (it.rwe)
            chk(reg_sel == it.sel && reg_wdata == it.rdat, "R7", "reg sel/data",
                {7'd0, reg_sel, reg_wdata}, {7'd0, it.sel, it.rdat});
          chk(flag_we == it.fwe, "R8", "flag_we", {15'd0, flag_we}, {15'd0, it.fwe});
          if (it.fwe)
            chk(flag_n == it.n && flag_z == it.z, "R8", "N/Z",
                {14'd0, flag_n, flag_z}, {14'd0, it.n, it.z});
        end
      end else begin
        chk(!(mem_we || mem_re || done), "R11", "activity while idle",
            {13'd0, mem_we, mem_re, done}, 16'd0);
      end
    end
  end

  task automatic run_op(input logic [1:0] c, input bit noisy);
    item_t a, b, d;
    logic [7:0] s0, s1, v;
    s0 = m_sp;
    a = '0; b = '0; d = '0;
    a.pl = c[1]; b.pl = c[1]; d.pl = c[1];
    a.spv = s0;
    if (!c[1]) begin
      v = c[0] ? y_val : x_val;
      b.we = 1'b1; b.dn = 1'b1; b.addr = {8'h01, s0}; b.wdata = v; b.spv = s0;
      shadow[s0] = v;
      m_sp = s0 - 8'd1;
      exp_q.push_back(a); exp_q.push_back(b);
    end else begin
      s1 = s0 + 8'd1;
      v = shadow[s1];
      b.spv = s1;
      d.re = 1'b1; d.dn = 1'b1; d.addr = {8'h01, s1}; d.spv = s1;
      d.rwe = 1'b1; d.sel = c[0]; d.rdat = v;
      d.fwe = 1'b1; d.n = v[7]; d.z = (v == 8'h00);
      m_sp = s1;
      exp_q.push_back(a); exp_q.push_back(b); exp_q.push_back(d);
    end
    @(negedge clk);
    start = 1'b1; op = c;
    @(negedge clk);
    if (!noisy) start = 1'b0;
    else begin
      op = ~c; sp_load = 1'b1; sp_load_val = 8'h55;
    end
    while (!done) @(negedge clk);
    start = 1'b0; sp_load = 1'b0;
    @(negedge clk);
    chk(sp == m_sp, noisy ? "R9" : (c[1] ? "R6" : "R4"), "final SP", {8'd0, sp}, {8'd0, m_sp});
    chk(exp_q.size() == 0, "R11", "expected cycles left", 16'(exp_q.size()), 16'd0);
  endtask

  task automatic load_sp(input logic [7:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    @(negedge clk);
    sp_load = 1'b0;
    m_sp = v;
    chk(sp == v, "R10", "SP after load", {8'd0, sp}, {8'd0, v});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      page[i]   = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    page[0] = 8'h00; shadow[0] = 8'h00;
    page[1] = 8'h80; shadow[1] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp == 8'hFF, "R1", "SP after reset", {8'd0, sp}, 16'h00FF);
    chk(!busy && !mem_we && !mem_re && !done && !reg_we && !flag_we, "R1",
        "outputs after reset", {10'd0, busy, mem_we, mem_re, done, reg_we, flag_we}, 16'd0);
    m_sp = 8'hFF;
    x_val = 8'hA5; y_val = 8'h3C;
    run_op(2'b00, 1'b0);   // push X at 0x01FF
    run_op(2'b01, 1'b0);   // push Y at 0x01FE
    run_op(2'b10, 1'b0);   // pull X reads 0x3C
    run_op(2'b11, 1'b0);   // pull Y reads 0xA5, N set
    run_op(2'b10, 1'b0);   // R6: SP FF wraps to 00, reads zero byte
    load_sp(8'h00);
    run_op(2'b11, 1'b0);   // pull Y at 0x0101, 0x80
    load_sp(8'h00);
    x_val = 8'h00; y_val = 8'h7E;
    run_op(2'b01, 1'b0);   // R4: push at 0x0100, SP wraps to FF
    load_sp(8'hFF);
    run_op(2'b00, 1'b1);   // R9: noisy start/op/sp_load while busy
    run_op(2'b01, 1'b1);
    run_op(2'b10, 1'b1);   // pulls back 0x7E
    run_op(2'b11, 1'b0);   // pulls back 0x00
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule